// File: doc/BRIEF.md
# Frame Job Control Register Bank

This block is a small bus-slave register bank that a host processor uses to set up and launch one frame-processing job. The host writes the image size, a set of operation-enable bits and per-channel threshold bounds, then writes a start request. The bank turns that request into a one-cycle start pulse for the image datapath. When the datapath finishes, it sends a done pulse. The bank latches the pulse into a flag that the host polls.

Every configuration field is driven straight out on its own port, so the datapath needs no decode logic. The bus side is a plain single-cycle interface. A write strobe, a read strobe and a word index share one address. Read data is registered and appears in the cycle after the read strobe. There is no channel handshaking.

Top module: `frame_job_regs`

## Requirements
- R1: After reset, every output port is zero. A read of any word returns zero until that word is written. The done flag reads zero.
- R2: Word index 0 is the job word. Bits 31:23 are the 9-bit image width, bits 22:14 the 9-bit image height and bits 6:1 the 6-bit operation enable. A write updates all three output fields at the clock edge, and a read of word 0 returns them in the same positions.
- R3: A write to word 0 with bit 0 set raises `start_o` for exactly the one cycle after the write edge. A write to word 0 with bit 0 clear produces no pulse.
- R4: In a read of word 0, bit 0 and bits 13:7 always return 0, whatever was written there.
- R5: Word index 1 is the status word, and its bit 0 is the done flag. A cycle with `done_i` high sets the flag. Only a write to word 0 with bit 0 set clears it. Any other write, including a write to word 0 with bit 0 clear, leaves it unchanged. Bits 31:1 of word 1 read as zero, and writes to word 1 are ignored.
- R6: When a start write and `done_i` fall in the same cycle, the start wins and the done flag ends that cycle clear.
- R7: Word indices 2 to 7 each hold one threshold channel, in the order hue, saturation, value, red, green, blue. Bits 7:0 are the low bound and bits 15:8 the high bound. Channel i drives `bound_lo_o[i*8 +: 8]` and `bound_hi_o[i*8 +: 8]`. Bits 31:16 of these words read as zero.
- R8: A write to a word index of 8 or more changes no output and no stored word. A read of such an index returns zero.
- R9: `rdata_o` is updated only in the cycle after `rd_en_i` is high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| img_width_o | output | 9 | Image width |
| img_height_o | output | 9 | Image height |
| op_sel_o | output | 6 | Operation enables |
| start_o | output | 1 | One-cycle job start pulse |
| done_i | input | 1 | Done pulse from the datapath |
| bound_lo_o | output | 48 | Low bounds, six 8-bit channels |
| bound_hi_o | output | 48 | High bounds, six 8-bit channels |

## Verification
A configuration register that is corrupt internally shows at once on its output port, in the cycle after the write that set it. The same value shows in `rdata_o` one cycle after a read strobe. A start register that sticks shows as a second cycle of `start_o` high. A done flag that is wrong shows only when the host reads word 1, so the bench reads that word after each done pulse, each start write and the collision case. A stray write decode shows as a changed field port after a write to another word or to an out-of-range index.

// File: rtl/fjr_pkg.sv
package fjr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned DIM_W    = 9;
  localparam int unsigned OP_W     = 6;
  localparam int unsigned NUM_CH   = 6;
  localparam int unsigned WIDTH_LSB  = 23;
  localparam int unsigned HEIGHT_LSB = 14;
  localparam int unsigned OP_LSB     = 1;
  localparam int unsigned START_BIT  = 0;
  localparam int unsigned IDX_JOB    = 0;
  localparam int unsigned IDX_STATUS = 1;
  localparam int unsigned IDX_BOUND0 = 2;
  localparam int unsigned NUM_WORDS  = IDX_BOUND0 + NUM_CH;
endpackage

// File: rtl/fjr_job_word.sv
module fjr_job_word
  import fjr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic [OP_W-1:0]   op_o,
  output logic              start_o
);
  logic [DIM_W-1:0] width_d, height_d;
  logic [OP_W-1:0]  op_d;
  logic             start_d;

  always_comb begin
    width_d  = width_o;
    height_d = height_o;
    op_d     = op_o;
    start_d  = 1'b0;
    if (wr_hit_i) begin
      width_d  = wdata_i[WIDTH_LSB  +: DIM_W];
      height_d = wdata_i[HEIGHT_LSB +: DIM_W];
      op_d     = wdata_i[OP_LSB     +: OP_W];
      start_d  = wdata_i[START_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o  <= '0;
      height_o <= '0;
      op_o     <= '0;
      start_o  <= 1'b0;
    end else begin
      start_o <= start_d;
      if (wr_hit_i) begin
        width_o  <= width_d;
        height_o <= height_d;
        op_o     <= op_d;
      end
    end
  end
endmodule

// File: rtl/fjr_status.sv
module fjr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic done_i,
  output logic done_flag_o
);
  logic done_d;
  logic done_en;

  always_comb begin
    done_en = start_wr_i | done_i;
    if (start_wr_i) done_d = 1'b0;
    else            done_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_flag_o <= 1'b0;
    else if (done_en) done_flag_o <= done_d;
  end
endmodule

// File: rtl/fjr_bound_bank.sv
module fjr_bound_bank
  import fjr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CH_W   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [2*CH_W-1:0]      wdata_i,
  output logic [NUM_CH*CH_W-1:0] lo_o,
  output logic [NUM_CH*CH_W-1:0] hi_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    logic [CH_W-1:0] lo_d, hi_d;
    assign hit = wr_en_i && (addr_i == ADDR_W'(IDX_BOUND0 + g));

    always_comb begin
      lo_d = lo_o[g*CH_W +: CH_W];
      hi_d = hi_o[g*CH_W +: CH_W];
      if (hit) begin
        lo_d = wdata_i[0    +: CH_W];
        hi_d = wdata_i[CH_W +: CH_W];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[g*CH_W +: CH_W] <= '0;
        hi_o[g*CH_W +: CH_W] <= '0;
      end else if (hit) begin
        lo_o[g*CH_W +: CH_W] <= lo_d;
        hi_o[g*CH_W +: CH_W] <= hi_d;
      end
    end
  end
endmodule

// File: rtl/fjr_read_port.sv
module fjr_read_port
  import fjr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CH_W   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DIM_W-1:0]       width_i,
  input  logic [DIM_W-1:0]       height_i,
  input  logic [OP_W-1:0]        op_i,
  input  logic                   done_i,
  input  logic [NUM_CH*CH_W-1:0] lo_i,
  input  logic [NUM_CH*CH_W-1:0] hi_i,
  output logic [DATA_W-1:0]      rdata_o
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADDR_W'(IDX_JOB)) begin
      rdata_d[WIDTH_LSB  +: DIM_W] = width_i;
      rdata_d[HEIGHT_LSB +: DIM_W] = height_i;
      rdata_d[OP_LSB     +: OP_W]  = op_i;
    end else if (addr_i == ADDR_W'(IDX_STATUS)) begin
      rdata_d[0] = done_i;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == ADDR_W'(IDX_BOUND0 + i)) begin
          rdata_d[0    +: CH_W] = lo_i[i*CH_W +: CH_W];
          rdata_d[CH_W +: CH_W] = hi_i[i*CH_W +: CH_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rdata_d;
  end
endmodule

// File: rtl/frame_job_regs.sv
module frame_job_regs
  import fjr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CH_W   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [8:0]             img_width_o,
  output logic [8:0]             img_height_o,
  output logic [5:0]             op_sel_o,
  output logic                   start_o,
  input  logic                   done_i,
  output logic [NUM_CH*CH_W-1:0] bound_lo_o,
  output logic [NUM_CH*CH_W-1:0] bound_hi_o
);
  localparam int unsigned BND_DATA_W = 2 * CH_W;

  logic job_hit, start_wr, done_flag;
  logic unused_pad_bits;

  assign job_hit  = wr_en_i && (addr_i == ADDR_W'(IDX_JOB));
  assign start_wr = job_hit && wdata_i[START_BIT];
  assign unused_pad_bits = ^wdata_i[HEIGHT_LSB-1:OP_LSB+OP_W];

  fjr_job_word u_job (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (job_hit),
    .wdata_i  (wdata_i),
    .width_o  (img_width_o),
    .height_o (img_height_o),
    .op_o     (op_sel_o),
    .start_o  (start_o)
  );

  fjr_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_wr_i  (start_wr),
    .done_i      (done_i),
    .done_flag_o (done_flag)
  );

  fjr_bound_bank #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_bounds (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i[BND_DATA_W-1:0]),
    .lo_o    (bound_lo_o),
    .hi_o    (bound_hi_o)
  );

  fjr_read_port #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_read (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .width_i  (img_width_o),
    .height_i (img_height_o),
    .op_i     (op_sel_o),
    .done_i   (done_flag),
    .lo_i     (bound_lo_o),
    .hi_i     (bound_hi_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/fjr_checker.sv
module fjr_checker #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [8:0]        img_width_o,
  input logic              start_o
);
  // R3: the start pulse never lasts two cycles
  a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3: a start write is followed by the pulse
  a_r3_start_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0 && wdata_i[0]) |=> start_o);
  // R4: start and pad bits of word 0 read as zero
  a_r4_job_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == '0) |=> (rdata_o[0] == 1'b0 && rdata_o[13:7] == 7'd0));
  // R8: out-of-range reads return zero
  a_r8_oor_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i >= ADDR_W'(8)) |=> (rdata_o == 32'd0));
  // R2: width changes only after a job word write
  a_r2_width_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == '0) |=> $stable(img_width_o));
  // R9: read data holds without a read strobe
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind frame_job_regs fjr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .img_width_o (img_width_o),
  .start_o     (start_o)
);

// File: tb/frame_job_regs_tb_top.sv
module frame_job_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i, rd_en_i, done_i;
  logic [3:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [8:0]  img_width_o, img_height_o;
  logic [5:0]  op_sel_o;
  logic        start_o;
  logic [47:0] bound_lo_o, bound_hi_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  frame_job_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .img_width_o(img_width_o), .img_height_o(img_height_o),
    .op_sel_o(op_sel_o), .start_o(start_o), .done_i(done_i),
    .bound_lo_o(bound_lo_o), .bound_hi_o(bound_hi_o)
  );

  // {is_read, addr, data}: data is write data or expected read data
  localparam logic [36:0] VEC [12] = '{
    {1'b1, 4'd1, 32'h0000_0000},
    {1'b0, 4'd0, 32'hA032_3FDA},
    {1'b1, 4'd0, 32'hA032_005A},
    {1'b0, 4'd2, 32'hDEAD_7F10},
    {1'b1, 4'd2, 32'h0000_7F10},
    {1'b0, 4'd5, 32'h0000_A55A},
    {1'b1, 4'd5, 32'h0000_A55A},
    {1'b0, 4'd7, 32'hFFFF_FF00},
    {1'b1, 4'd7, 32'h0000_FF00},
    {1'b0, 4'd9, 32'h0000_1234},
    {1'b1, 4'd9, 32'h0000_0000},
    {1'b1, 4'd1, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic pulse_done();
    @(negedge clk_i);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_ni = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0; done_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs", {img_width_o, img_height_o, op_sel_o, start_o}, '0);
    chk("R1 bounds", {bound_lo_o[15:0], bound_hi_o[15:0]}, '0);
    chk("R1 rdata", rdata_o, '0);
    do_read(4'd0, rd); chk("R1 word0", rd, '0);

    // vector table: R2 R4 R5 R7 R8
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][36]) begin
        do_read(VEC[i][35:32], rd);
        chk($sformatf("R2/R4/R7/R8 vec%0d", i), rd, VEC[i][31:0]);
      end else begin
        do_write(VEC[i][35:32], VEC[i][31:0]);
        chk($sformatf("R3 no pulse vec%0d", i), start_o, 1'b0);
      end
    end
    chk("R2 width", img_width_o, 9'd320);
    chk("R2 height", img_height_o, 9'd200);
    chk("R2 op", op_sel_o, 6'h2D);
    chk("R7 hue bounds", {bound_hi_o[7:0], bound_lo_o[7:0]}, 16'h7F10);
    chk("R7 red bounds", {bound_hi_o[31:24], bound_lo_o[31:24]}, 16'hA55A);
    chk("R7 blue bounds", {bound_hi_o[47:40], bound_lo_o[47:40]}, 16'hFF00);

    // R9 hold without read strobe
    @(negedge clk_i);
    chk("R9 rdata hold", rdata_o, 32'h0);

    // R3 start pulse
    do_write(4'd0, 32'hA032_005B);
    chk("R3 pulse high", start_o, 1'b1);
    @(negedge clk_i);
    chk("R3 pulse low", start_o, 1'b0);
    do_read(4'd0, rd); chk("R4 start reads 0", rd, 32'hA032_005A);

    // R5 done flag
    pulse_done();
    do_read(4'd1, rd); chk("R5 done set", rd, 32'h1);
    do_write(4'd0, 32'hA032_005A);
    do_write(4'd1, 32'h0);
    do_read(4'd1, rd); chk("R5 kept without start", rd, 32'h1);
    do_write(4'd0, 32'hA032_005B);
    do_read(4'd1, rd); chk("R5 cleared by start", rd, 32'h0);

    // R6 collision
    pulse_done();
    do_read(4'd1, rd); chk("R6 pre-set", rd, 32'h1);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 4'd0; wdata_i = 32'hA032_005B; done_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; done_i = 1'b0;
    do_read(4'd1, rd); chk("R6 start wins", rd, 32'h0);

    // R8 out-of-range write changes nothing
    do_write(4'd8, 32'hFFFF_FFFF);
    do_write(4'd15, 32'hFFFF_FFFF);
    chk("R8 job fields", {img_width_o, img_height_o, op_sel_o, start_o},
        {9'd320, 9'd200, 6'h2D, 1'b0});
    chk("R8 bounds", {bound_hi_o, bound_lo_o},
        {8'hFF, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h7F,
         8'h00, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h10});
    do_read(4'd15, rd); chk("R8 read zero", rd, 32'h0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule